// File: doc/BRIEF.md
# Timer Bank Register Decoder

This block is the register front end for a bank of eight timer channels. It takes word accesses from a simple request bus (valid, write, address, write data) and turns each one into a register access on one channel, or on one of the shared words: the control word, the interrupt-status word, or a write-to-clear alias of the control word. The channels themselves sit outside the block. They see a shared channel index, a register index and write data, plus a one-hot write strobe, and they return read data for whichever register is selected.

The control word holds four bits per channel. When the control word changes, the new value is applied in three steps on three consecutive clock edges. Channels being switched off stop first. The clock-source, overflow-interrupt and pulse fields change next. Channels being switched on start last. A channel therefore never runs with a half-updated configuration.

Every access receives a response one cycle later. The response carries the read data and an error flag.

Top module: `tmrbank_regif`

## Requirements
- R1: Channel c, register r (0 live count, 1 reload, 2 first match, 3 second match) sits at byte offset 16*s + 4*r, where s = c for c < 3 and s = c + 1 for c >= 3. A write there raises only `ch_wr_en[c]`, in the same cycle, with `ch_sel` = c, `ch_reg` = r and `ch_wdata` = the written data.
- R2: Every access gives `rsp_valid` high on the next cycle. A read of a channel register returns `ch_rdata` on `rsp_rdata` in that response. Writes respond with zero data.
- R3: Offset 0x30 holds the control word. Channel c owns bits 4c..4c+3: bit 4c is enable, 4c+1 external clock, 4c+2 overflow interrupt, 4c+3 pulse enable. The word is driven on `ctrl_o` and reads back at 0x30.
- R4: A control update accepted at clock edge E is applied in three steps. At E, enables going 1→0 clear. At E+1, the other three fields of every channel take their new values. At E+2, enables going 0→1 set.
- R5: On channels 0 to 3 the pulse-enable bit cannot be set. A write to 0x30 that sets one of those bits leaves it 0, still applies the rest of the word, and responds with `rsp_err` = 1.
- R6: Offset 0x34 reads the per-channel interrupt-status bits (bit c for channel c). A pulse on `irq_evt[c]` sets bit c. A write ANDs the written data into the bits. An event arriving in the same cycle as an AND write still sets its bit.
- R7: A write to 0x3C clears every control bit that is 1 in the written data, using the ordering of R4. A read of 0x3C returns 0 with no error.
- R8: A misaligned address (low two bits not 00), offset 0x38, or an offset above the last channel (0x8C) responds with `rsp_err` = 1 and zero data. It changes no control bit, no status bit and no channel register.
- R9: Synchronous reset clears the control word, the interrupt-status bits, `rsp_valid` and `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data of the response |
| rsp_err | output | 1 | Error flag of the response |
| ch_sel | output | 3 | Selected channel index |
| ch_reg | output | 2 | Selected channel register |
| ch_wr_en | output | 8 | One-hot channel write strobe |
| ch_wdata | output | 32 | Channel write data |
| ch_rdata | input | 32 | Read data of the selected channel register |
| irq_evt | input | 8 | Per-channel interrupt event pulses |
| ctrl_o | output | 32 | Applied control word, four bits per channel |

## Verification
The hardest situation to create is the middle of the three-step control update. There, a channel has already been switched off, or its fields have changed, but its enable has not yet been set again, and that state lasts only one cycle. The stimulus programs a word in which one channel's enable falls and another's rises while both change their other fields. It then samples `ctrl_o` after each of the three edges. The clear alias and a word that mixes a forbidden pulse bit with legal ones go through the same cycle-by-cycle sampling. A further case drives an interrupt event in the same cycle as an AND write to the status word.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;

    localparam int NIB_W = 4;

    typedef struct packed {
        logic pulse;
        logic ovf_irq;
        logic ext_clk;
        logic en;
    } chctl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_FIELDS,
        SEQ_ENABLE
    } seq_ph_t;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_CHAN,
        HIT_CTRL,
        HIT_IRQ,
        HIT_CLR
    } hit_t;

endpackage

// File: rtl/tmrbank_addr_dec.sv
module tmrbank_addr_dec
    import tmrbank_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int ADDR_W      = 8,
    parameter int SHARED_SLOT = 3,
    localparam int CIDX_W     = $clog2(NCH),
    localparam int SLOT_W     = ADDR_W - 4
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              kind,
    output logic [CIDX_W-1:0] chan,
    output logic [1:0]        regsel
);

    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] slot_m1;

    assign slot    = addr[ADDR_W-1:4];
    assign slot_m1 = slot - SLOT_W'(1);
    assign regsel  = addr[3:2];

    always_comb begin
        kind = HIT_NONE;
        chan = '0;
        if (addr[1:0] != 2'b00) begin
            kind = HIT_NONE;
        end else if (slot < SLOT_W'(SHARED_SLOT)) begin
            kind = HIT_CHAN;
            chan = slot[CIDX_W-1:0];
        end else if (slot == SLOT_W'(SHARED_SLOT)) begin
            case (addr[3:2])
                2'd0:    kind = HIT_CTRL;
                2'd1:    kind = HIT_IRQ;
                2'd3:    kind = HIT_CLR;
                default: kind = HIT_NONE;
            endcase
        end else if (slot <= SLOT_W'(NCH)) begin
            kind = HIT_CHAN;
            chan = slot_m1[CIDX_W-1:0];
        end
    end

endmodule

// File: rtl/tmrbank_ctrl_seq.sv
module tmrbank_ctrl_seq
    import tmrbank_pkg::*;
#(
    parameter int NCH            = 8,
    parameter int FIRST_PULSE_CH = 4,
    localparam int CTRL_W        = NIB_W * NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CTRL_W-1:0] tgt_raw,
    output logic [CTRL_W-1:0] ctrl,
    output logic              pulse_viol
);

    chctl_t [NCH-1:0] raw_v;
    chctl_t [NCH-1:0] tgt_v;
    chctl_t [NCH-1:0] cur_q;
    chctl_t [NCH-1:0] pend_q;
    seq_ph_t          ph_q;
    logic [NCH-1:0]   low_pulse_req;
    logic [NCH-1:0]   low_pulse_now;
    logic [NCH-1:0]   en_now;
    logic [CTRL_W-1:0] other_now;

    assign raw_v = tgt_raw;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c < FIRST_PULSE_CH) begin : g_nopulse
            assign tgt_v[c]         = '{pulse: 1'b0, ovf_irq: raw_v[c].ovf_irq,
                                        ext_clk: raw_v[c].ext_clk, en: raw_v[c].en};
            assign low_pulse_req[c] = raw_v[c].pulse;
            assign low_pulse_now[c] = cur_q[c].pulse;
        end else begin : g_pulse
            assign tgt_v[c]         = raw_v[c];
            assign low_pulse_req[c] = 1'b0;
            assign low_pulse_now[c] = 1'b0;
        end
        assign en_now[c] = cur_q[c].en;
        assign other_now[NIB_W*c +: NIB_W] =
            {cur_q[c].pulse, cur_q[c].ovf_irq, cur_q[c].ext_clk, 1'b0};
    end

    assign pulse_viol = load & (|low_pulse_req);
    assign ctrl       = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            pend_q <= '0;
            ph_q   <= SEQ_IDLE;
        end else if (load) begin
            for (int c = 0; c < NCH; c++) begin
                cur_q[c].en <= cur_q[c].en & tgt_v[c].en;
            end
            pend_q <= tgt_v;
            ph_q   <= SEQ_FIELDS;
        end else begin
            case (ph_q)
                SEQ_FIELDS: begin
                    for (int c = 0; c < NCH; c++) begin
                        cur_q[c].ext_clk <= pend_q[c].ext_clk;
                        cur_q[c].ovf_irq <= pend_q[c].ovf_irq;
                        cur_q[c].pulse   <= pend_q[c].pulse;
                    end
                    ph_q <= SEQ_ENABLE;
                end
                SEQ_ENABLE: begin
                    cur_q <= pend_q;
                    ph_q  <= SEQ_IDLE;
                end
                default: ph_q <= SEQ_IDLE;
            endcase
        end
    end

    assert_en_rise_last_R4: assert property (@(posedge clk) disable iff (rst)
        (|(en_now & ~$past(en_now))) |-> ($past(ph_q) == SEQ_ENABLE));

    assert_fields_hold_on_en_R4: assert property (@(posedge clk) disable iff (rst)
        (en_now != $past(en_now)) |-> (other_now == $past(other_now)));

    assert_low_pulse_zero_R5: assert property (@(posedge clk) disable iff (rst)
        low_pulse_now == '0);

endmodule

// File: rtl/tmrbank_irq_stat.sv
module tmrbank_irq_stat #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt,
    input  logic           wr_and,
    input  logic [NCH-1:0] wmask,
    output logic [NCH-1:0] status
);

    logic [NCH-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= (wr_and ? (st_q & wmask) : st_q) | evt;
        end
    end

    assign status = st_q;

    assert_clear_needs_write_R6: assert property (@(posedge clk) disable iff (rst)
        (|($past(st_q) & ~st_q)) |-> $past(wr_and));

    assert_event_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((st_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/tmrbank_regif.sv
module tmrbank_regif
    import tmrbank_pkg::*;
#(
    parameter int NCH            = 8,
    parameter int FIRST_PULSE_CH = 4,
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32,
    localparam int CIDX_W        = $clog2(NCH),
    localparam int CTRL_W        = NIB_W * NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [CIDX_W-1:0] ch_sel,
    output logic [1:0]        ch_reg,
    output logic [NCH-1:0]    ch_wr_en,
    output logic [DATA_W-1:0] ch_wdata,
    input  logic [DATA_W-1:0] ch_rdata,
    input  logic [NCH-1:0]    irq_evt,
    output logic [CTRL_W-1:0] ctrl_o
);

    hit_t              kind;
    logic [CIDX_W-1:0] chan;
    logic [1:0]        regsel;
    logic              wr;
    logic              ctrl_load;
    logic [CTRL_W-1:0] ctrl_tgt;
    logic              pulse_viol;
    logic [NCH-1:0]    irq_status;
    logic [DATA_W-1:0] rd_val;
    logic              acc_err;

    tmrbank_addr_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .addr   (req_addr),
        .kind   (kind),
        .chan   (chan),
        .regsel (regsel)
    );

    assign wr        = req_valid & req_write;
    assign ch_sel    = chan;
    assign ch_reg    = regsel;
    assign ch_wdata  = req_wdata;
    assign ctrl_load = wr & ((kind == HIT_CTRL) | (kind == HIT_CLR));
    assign ctrl_tgt  = (kind == HIT_CTRL) ? req_wdata[CTRL_W-1:0]
                                          : (ctrl_o & ~req_wdata[CTRL_W-1:0]);

    always_comb begin
        ch_wr_en = '0;
        for (int c = 0; c < NCH; c++) begin
            ch_wr_en[c] = wr && (kind == HIT_CHAN) && (chan == CIDX_W'(c));
        end
    end

    tmrbank_ctrl_seq #(.NCH(NCH), .FIRST_PULSE_CH(FIRST_PULSE_CH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .load       (ctrl_load),
        .tgt_raw    (ctrl_tgt),
        .ctrl       (ctrl_o),
        .pulse_viol (pulse_viol)
    );

    tmrbank_irq_stat #(.NCH(NCH)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (irq_evt),
        .wr_and (wr & (kind == HIT_IRQ)),
        .wmask  (req_wdata[NCH-1:0]),
        .status (irq_status)
    );

    always_comb begin
        rd_val = '0;
        case (kind)
            HIT_CHAN: rd_val = ch_rdata;
            HIT_CTRL: rd_val[CTRL_W-1:0] = ctrl_o;
            HIT_IRQ:  rd_val[NCH-1:0] = irq_status;
            default:  rd_val = '0;
        endcase
    end

    assign acc_err = req_valid & ((kind == HIT_NONE) | pulse_viol);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
            rsp_err   <= acc_err;
        end
    end

    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_wr_en));

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0));

    assert_err_has_req_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> $past(req_valid));

endmodule

// File: tb/tmrbank_regif_tb.sv
module tmrbank_regif_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [2:0]  ch_sel;
    logic [1:0]  ch_reg;
    logic [7:0]  ch_wr_en;
    logic [31:0] ch_wdata;
    logic [31:0] ch_rdata;
    logic [7:0]  irq_evt = '0;
    logic [31:0] ctrl_o;

    int vectors = 0;
    int miscompares = 0;

    typedef struct {
        logic [31:0] rd;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    logic [31:0] stub [8][4];
    logic [31:0] model [8][4];
    logic [7:0]  last_strobe;
    logic [2:0]  last_sel;
    logic [1:0]  last_reg;

    always #5 clk = ~clk;

    tmrbank_regif u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .ch_sel(ch_sel),
        .ch_reg(ch_reg), .ch_wr_en(ch_wr_en), .ch_wdata(ch_wdata),
        .ch_rdata(ch_rdata), .irq_evt(irq_evt), .ctrl_o(ctrl_o)
    );

    // channel register stubs
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 8; c++)
                for (int r = 0; r < 4; r++) stub[c][r] <= '0;
        end else begin
            for (int c = 0; c < 8; c++)
                if (ch_wr_en[c]) stub[c][ch_reg] <= ch_wdata;
        end
    end
    assign ch_rdata = stub[ch_sel][ch_reg];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected response per bus response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sbq.size() == 0) begin
                chk("R2 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk({e.tag, " rdata"}, rsp_rdata, e.rd);
                chk({e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
            end
        end
    end

    // driver: one access, called at a falling edge, returns at the next one
    task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                          input logic [31:0] exp_rd, input logic exp_err, input string tag);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        sbq.push_back('{exp_rd, exp_err, tag});
        #1;
        last_strobe = ch_wr_en;
        last_sel    = ch_sel;
        last_reg    = ch_reg;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    function automatic logic [7:0] chan_addr(input int c, input int r);
        int s;
        s = (c < 3) ? c : c + 1;
        return 8'(s * 16 + r * 4);
    endfunction

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 4; r++) model[c][r] = '0;
        repeat (3) @(negedge clk);
        chk("R9 ctrl after reset", ctrl_o, 32'h0);
        chk("R9 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R9 rsp_err after reset", {31'd0, rsp_err}, 32'd0);
        rst = 1'b0;
        access(1'b0, 8'h30, 0, 32'h0, 1'b0, "R9 ctrl read");
        access(1'b0, 8'h34, 0, 32'h0, 1'b0, "R9 status read");

        // R1: every channel register write
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 4; r++) begin
                logic [31:0] d;
                d = 32'hA500_0000 | (c << 8) | (r << 4) | 32'h3;
                access(1'b1, chan_addr(c, r), d, 32'h0, 1'b0, "R1 chan write");
                chk("R1 strobe", {24'd0, last_strobe}, 32'd1 << c);
                chk("R1 sel", {29'd0, last_sel}, 32'(c));
                chk("R1 reg", {30'd0, last_reg}, 32'(r));
                model[c][r] = d;
            end
        end
        // R2: read back all of them
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 4; r++)
                access(1'b0, chan_addr(c, r), 0, model[c][r], 1'b0, "R2 chan read");

        // R8: misaligned channel write does nothing
        access(1'b1, 8'h02, 32'hDEAD_BEEF, 32'h0, 1'b1, "R8 misaligned write");
        chk("R8 no strobe misaligned", {24'd0, last_strobe}, 32'h0);
        access(1'b0, 8'h00, 0, model[0][0], 1'b0, "R8 ch0 unchanged");

        // R3: enable channels 0 and 1
        access(1'b1, 8'h30, 32'h0000_0011, 32'h0, 1'b0, "R3 ctrl write");
        repeat (2) @(negedge clk);
        chk("R3 ctrl_o", ctrl_o, 32'h0000_0011);
        access(1'b0, 8'h30, 0, 32'h0000_0011, 1'b0, "R3 ctrl readback");

        // R4: ch0 and ch1 switch off, ch1 and ch2 change fields, ch2 switches on
        access(1'b1, 8'h30, 32'h0000_0560, 32'h0, 1'b0, "R4 ctrl write");
        chk("R4 step1 disables", ctrl_o, 32'h0000_0000);
        @(negedge clk);
        chk("R4 step2 fields", ctrl_o, 32'h0000_0460);
        @(negedge clk);
        chk("R4 step3 enables", ctrl_o, 32'h0000_0560);

        // R5: pulse on ch3 refused, on ch4 accepted
        access(1'b1, 8'h30, 32'h0008_8560, 32'h0, 1'b1, "R5 pulse write");
        repeat (2) @(negedge clk);
        chk("R5 ctrl_o", ctrl_o, 32'h0008_0560);

        // R7: clear ch4 pulse and ch2 enable
        access(1'b1, 8'h3C, 32'h0008_0100, 32'h0, 1'b0, "R7 clear write");
        chk("R7 step1", ctrl_o, 32'h0008_0460);
        @(negedge clk);
        chk("R7 step2", ctrl_o, 32'h0000_0460);
        @(negedge clk);
        chk("R7 step3", ctrl_o, 32'h0000_0460);
        access(1'b0, 8'h3C, 0, 32'h0, 1'b0, "R7 alias read");

        // R6: interrupt status
        irq_evt = 8'h05;
        @(negedge clk);
        irq_evt = 8'h00;
        access(1'b0, 8'h34, 0, 32'h05, 1'b0, "R6 status read");
        access(1'b1, 8'h34, 32'hFFFF_FFFE, 32'h0, 1'b0, "R6 and write");
        access(1'b0, 8'h34, 0, 32'h04, 1'b0, "R6 after and");
        irq_evt = 8'h80;
        access(1'b1, 8'h34, 32'h0, 32'h0, 1'b0, "R6 and with event");
        irq_evt = 8'h00;
        access(1'b0, 8'h34, 0, 32'h80, 1'b0, "R6 event wins");

        // R8: undefined offsets
        access(1'b1, 8'h38, 32'hFFFF_FFFF, 32'h0, 1'b1, "R8 write 0x38");
        access(1'b0, 8'h38, 0, 32'h0, 1'b1, "R8 read 0x38");
        access(1'b0, 8'h90, 0, 32'h0, 1'b1, "R8 read 0x90");
        access(1'b1, 8'h90, 32'h1234_5678, 32'h0, 1'b1, "R8 write 0x90");
        chk("R8 no strobe 0x90", {24'd0, last_strobe}, 32'h0);
        access(1'b1, 8'h31, 32'h0, 32'h0, 1'b1, "R8 misaligned ctrl");
        access(1'b1, 8'h35, 32'h0, 32'h0, 1'b1, "R8 misaligned status");
        repeat (3) @(negedge clk);
        chk("R8 ctrl unchanged", ctrl_o, 32'h0000_0460);
        access(1'b0, 8'h30, 0, 32'h0000_0460, 1'b0, "R8 ctrl readback");
        access(1'b0, 8'h34, 0, 32'h80, 1'b0, "R8 status readback");
        access(1'b0, chan_addr(7, 3), 0, model[7][3], 1'b0, "R8 ch7 unchanged");

        repeat (2) @(negedge clk);
        chk("R2 all responses seen", 32'(sbq.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule